// File: doc/BRIEF.md
# Per-Class Transmit Queue Manager

This block keeps the transmit queues of a single output port. Each priority class holds two stores side by side: unicast frames are chained as a linked list of frame-control handles, and multicast frames sit in a small physical FIFO of their own. Every switch response brings a handle, a unicast/multicast flag, a class, the source port number and whether that source port takes flow control. From class occupancy and a port-wide reserve, the block decides whether to queue the frame, drop it, or queue it while asking the source to pause.

When the port pulses ready, a strict-priority scheduler picks the highest non-empty class. Within that class, the unicast list and the multicast FIFO act as one queue: each entry carries a wrapping arrival stamp, and the head with the older stamp leaves first. The dequeued handle, its class and its kind are presented one cycle later. Frame data and buffer memory are handled elsewhere.

Top module: `txq_port_mgr`

## Requirements
- R1: The parameter HIGH_SPEED selects the class count: 0 gives 2 classes, 1 gives 4, and the class fields are $clog2 of that count wide.
- R2: Unicast handles of one class leave in the order they were accepted.
- R3: Each class has a multicast FIFO of MC_DEPTH entries; a multicast response for a class whose FIFO is full is dropped whatever the flow-control setting.
- R4: Within a class, of the unicast head and the multicast head the one accepted earlier leaves first, and this order holds across wraparound of the STAMP_W-bit arrival counter.
- R5: A dequeue serves the highest-numbered non-empty class (class NC-1 is the most urgent).
- R6: Each cycle with deq_ready_i high and some class non-empty yields deq_valid_o high on the next cycle with handle, class and deq_mcast_o (1 = multicast); with all classes empty deq_valid_o stays low and the other dequeue outputs read zero.
- R7: A class is congested when its occupancy (unicast plus multicast entries) is at or above its limit, taken from bits [c*CNT_W +: CNT_W] of class_limit_i, or when the port-wide entry count is at or above GLOBAL_RES.
- R8: A response for a congested class from a source without flow control is dropped: drop_o pulses one cycle after the response and nothing is queued.
- R9: A response for a congested class from a source with flow control raises fc_req_o with fc_port_o set to the source number one cycle later, and the frame is queued unless R3 drops it.
- R10: An accepted multicast response pulses mc_dup_o with its handle on mc_dup_handle_o one cycle later, so the duplicate count can be raised; unicast or dropped responses leave both at zero.
- R11: Reset empties every queue and clears all registered outputs.
- R12: An enqueue and a dequeue in the same cycle, on the same class holding a single unicast entry, both take effect: the old head leaves and the new handle becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid_i | input | 1 | Switch response present |
| rsp_handle_i | input | HANDLE_W | Frame-control handle |
| rsp_mcast_i | input | 1 | 1 = multicast frame |
| rsp_class_i | input | CLS_W | Priority class |
| rsp_src_i | input | SRC_W | Source port number |
| rsp_fc_en_i | input | 1 | Source port takes flow control |
| class_limit_i | input | NC*CNT_W | Per-class occupancy limits |
| deq_ready_i | input | 1 | Port can take one frame |
| drop_o | output | 1 | Response was dropped |
| fc_req_o | output | 1 | Pause request toward source |
| fc_port_o | output | SRC_W | Source port to pause |
| mc_dup_o | output | 1 | Multicast frame accepted |
| mc_dup_handle_o | output | HANDLE_W | Handle of that multicast frame |
| deq_valid_o | output | 1 | Dequeued handle present |
| deq_handle_o | output | HANDLE_W | Dequeued handle |
| deq_class_o | output | CLS_W | Class it came from |
| deq_mcast_o | output | 1 | 1 = came from the multicast FIFO |

## Verification
The assertions take for granted that a handle is never queued twice at once, since the linked list stores next pointers by handle, and that fewer than half the arrival-counter range of entries are queued, so the age comparison is meaningful. The stimulus reuses a handle only after it has been dequeued and keeps at most a few dozen entries outstanding, far below the 128 the default stamp width allows. Dequeue requests on empty queues are legal and are exercised on purpose.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Which store of a class supplies the next frame
  typedef enum logic {HEAD_UC = 1'b0, HEAD_MC = 1'b1} head_src_e;

  // Age test on wrapping stamps: a was stamped before b
  function automatic logic stamp_before(input logic [31:0] diff, input int unsigned w);
    return diff[w-1];
  endfunction
endpackage

// File: rtl/txq_uc_list.sv
module txq_uc_list #(
  parameter int HANDLE_W = 6,
  parameter int STAMP_W  = 8,
  parameter int CNT_W    = 8,
  localparam int NH      = 2 ** HANDLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_i,
  input  logic [HANDLE_W-1:0] push_handle_i,
  input  logic [STAMP_W-1:0]  push_stamp_i,
  input  logic                pop_i,
  output logic                empty_o,
  output logic [HANDLE_W-1:0] head_handle_o,
  output logic [STAMP_W-1:0]  head_stamp_o,
  output logic [CNT_W-1:0]    count_o
);
  // Next pointer and arrival stamp, both addressed by handle
  logic [HANDLE_W-1:0] next_mem  [NH];
  logic [STAMP_W-1:0]  stamp_mem [NH];
  logic [HANDLE_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0]    count_q;

  always_ff @(posedge clk) begin
    if (push_i) stamp_mem[push_handle_i] <= push_stamp_i;
    if (push_i && count_q != '0) next_mem[tail_q] <= push_handle_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
      if (push_i) tail_q <= push_handle_i;
      if (push_i && (count_q == '0 || (count_q == CNT_W'(1) && pop_i)))
        head_q <= push_handle_i;
      else if (pop_i)
        head_q <= next_mem[head_q];
    end
  end

  assign empty_o       = (count_q == '0);
  assign head_handle_o = head_q;
  assign head_stamp_o  = stamp_mem[head_q];
  assign count_o       = count_q;

  // R6: the scheduler only pops a list that holds something
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> count_q != '0);
endmodule

// File: rtl/txq_mc_fifo.sv
module txq_mc_fifo #(
  parameter int HANDLE_W = 6,
  parameter int STAMP_W  = 8,
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 8,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W   = HANDLE_W + STAMP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_i,
  input  logic [HANDLE_W-1:0] push_handle_i,
  input  logic [STAMP_W-1:0]  push_stamp_i,
  input  logic                pop_i,
  output logic                empty_o,
  output logic                full_o,
  output logic [HANDLE_W-1:0] head_handle_o,
  output logic [STAMP_W-1:0]  head_stamp_o,
  output logic [CNT_W-1:0]    count_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= {push_handle_i, push_stamp_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign {head_handle_o, head_stamp_o} = mem[rd_q];
  assign count_o = count_q;

  // R3: admission never writes into a full multicast FIFO
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/txq_admit.sv
module txq_admit #(
  parameter int CNT_W      = 8,
  parameter int TOT_W      = 10,
  parameter int GLOBAL_RES = 12
) (
  input  logic             mcast_i,
  input  logic             fc_en_i,
  input  logic             mc_full_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [TOT_W-1:0] total_i,
  output logic             drop_o,
  output logic             fc_o
);
  logic congested, hard_full;

  always_comb begin
    congested = (occ_i >= limit_i) || (total_i >= TOT_W'(GLOBAL_RES));
    hard_full = mcast_i && mc_full_i;
    drop_o    = hard_full || (congested && !fc_en_i);
    fc_o      = congested && fc_en_i;
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NC    = 4,
  parameter int CLS_W = 2
) (
  input  logic [NC-1:0]    req_i,
  output logic [NC-1:0]    grant_o,
  output logic [CLS_W-1:0] idx_o,
  output logic             any_o
);
  // Higher index overrides lower: strict priority
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = 0; i < NC; i++) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = CLS_W'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/txq_port_mgr.sv
module txq_port_mgr #(
  parameter bit HIGH_SPEED = 1'b0,
  parameter int HANDLE_W   = 6,
  parameter int MC_DEPTH   = 4,
  parameter int STAMP_W    = 8,
  parameter int GLOBAL_RES = 12,
  parameter int SRC_W      = 3,
  localparam int NC        = HIGH_SPEED ? 4 : 2,
  localparam int CLS_W     = $clog2(NC),
  localparam int CNT_W     = HANDLE_W + 2,
  localparam int TOT_W     = CNT_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rsp_valid_i,
  input  logic [HANDLE_W-1:0] rsp_handle_i,
  input  logic                rsp_mcast_i,
  input  logic [CLS_W-1:0]    rsp_class_i,
  input  logic [SRC_W-1:0]    rsp_src_i,
  input  logic                rsp_fc_en_i,
  input  logic [NC*CNT_W-1:0] class_limit_i,
  input  logic                deq_ready_i,
  output logic                drop_o,
  output logic                fc_req_o,
  output logic [SRC_W-1:0]    fc_port_o,
  output logic                mc_dup_o,
  output logic [HANDLE_W-1:0] mc_dup_handle_o,
  output logic                deq_valid_o,
  output logic [HANDLE_W-1:0] deq_handle_o,
  output logic [CLS_W-1:0]    deq_class_o,
  output logic                deq_mcast_o
);
  import txq_pkg::*;

  logic [NC-1:0]       uc_empty, mc_empty, mc_full, nonempty, grant;
  logic [NC-1:0]       push_uc, push_mc, pop_uc, pop_mc;
  logic [HANDLE_W-1:0] uc_head [NC];
  logic [HANDLE_W-1:0] mc_head [NC];
  logic [STAMP_W-1:0]  uc_st   [NC];
  logic [STAMP_W-1:0]  mc_st   [NC];
  logic [CNT_W-1:0]    uc_cnt  [NC];
  logic [CNT_W-1:0]    mc_cnt  [NC];
  logic [CNT_W-1:0]    occ     [NC];
  logic [CNT_W-1:0]    lim     [NC];
  head_src_e           pick    [NC];
  logic [TOT_W-1:0]    total;
  logic [STAMP_W-1:0]  stamp_q;
  logic [CLS_W-1:0]    gidx;
  logic                any_ne, drop_d, fc_d, accept;

  txq_admit #(.CNT_W(CNT_W), .TOT_W(TOT_W), .GLOBAL_RES(GLOBAL_RES)) i_admit (
    .mcast_i  (rsp_mcast_i),
    .fc_en_i  (rsp_fc_en_i),
    .mc_full_i(mc_full[rsp_class_i]),
    .occ_i    (occ[rsp_class_i]),
    .limit_i  (lim[rsp_class_i]),
    .total_i  (total),
    .drop_o   (drop_d),
    .fc_o     (fc_d)
  );

  assign accept = rsp_valid_i && !drop_d;

  txq_sched #(.NC(NC), .CLS_W(CLS_W)) i_sched (
    .req_i  (nonempty),
    .grant_o(grant),
    .idx_o  (gidx),
    .any_o  (any_ne)
  );

  for (genvar c = 0; c < NC; c++) begin : g_cls
    logic               sel;
    logic [STAMP_W-1:0] age_diff;

    assign lim[c]      = class_limit_i[c*CNT_W +: CNT_W];
    assign sel         = (rsp_class_i == CLS_W'(c));
    assign push_uc[c]  = accept && sel && !rsp_mcast_i;
    assign push_mc[c]  = accept && sel && rsp_mcast_i;
    assign age_diff    = uc_st[c] - mc_st[c];
    assign pick[c]     = (!uc_empty[c] &&
                          (mc_empty[c] || stamp_before(32'(age_diff), STAMP_W)))
                         ? HEAD_UC : HEAD_MC;
    assign pop_uc[c]   = deq_ready_i && grant[c] && (pick[c] == HEAD_UC);
    assign pop_mc[c]   = deq_ready_i && grant[c] && (pick[c] == HEAD_MC);
    assign nonempty[c] = !uc_empty[c] || !mc_empty[c];
    assign occ[c]      = uc_cnt[c] + mc_cnt[c];

    txq_uc_list #(.HANDLE_W(HANDLE_W), .STAMP_W(STAMP_W), .CNT_W(CNT_W)) i_uc (
      .clk, .rst,
      .push_i       (push_uc[c]),
      .push_handle_i(rsp_handle_i),
      .push_stamp_i (stamp_q),
      .pop_i        (pop_uc[c]),
      .empty_o      (uc_empty[c]),
      .head_handle_o(uc_head[c]),
      .head_stamp_o (uc_st[c]),
      .count_o      (uc_cnt[c])
    );

    txq_mc_fifo #(.HANDLE_W(HANDLE_W), .STAMP_W(STAMP_W), .DEPTH(MC_DEPTH),
                  .CNT_W(CNT_W)) i_mc (
      .clk, .rst,
      .push_i       (push_mc[c]),
      .push_handle_i(rsp_handle_i),
      .push_stamp_i (stamp_q),
      .pop_i        (pop_mc[c]),
      .empty_o      (mc_empty[c]),
      .full_o       (mc_full[c]),
      .head_handle_o(mc_head[c]),
      .head_stamp_o (mc_st[c]),
      .count_o      (mc_cnt[c])
    );
  end

  always_comb begin
    total = '0;
    for (int c = 0; c < NC; c++) total = total + TOT_W'(occ[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q         <= '0;
      drop_o          <= 1'b0;
      fc_req_o        <= 1'b0;
      fc_port_o       <= '0;
      mc_dup_o        <= 1'b0;
      mc_dup_handle_o <= '0;
      deq_valid_o     <= 1'b0;
      deq_handle_o    <= '0;
      deq_class_o     <= '0;
      deq_mcast_o     <= 1'b0;
    end else begin
      if (accept) stamp_q <= stamp_q + 1'b1;
      drop_o          <= rsp_valid_i && drop_d;
      fc_req_o        <= rsp_valid_i && fc_d;
      fc_port_o       <= (rsp_valid_i && fc_d) ? rsp_src_i : '0;
      mc_dup_o        <= accept && rsp_mcast_i;
      mc_dup_handle_o <= (accept && rsp_mcast_i) ? rsp_handle_i : '0;
      deq_valid_o     <= deq_ready_i && any_ne;
      if (deq_ready_i && any_ne) begin
        deq_class_o  <= gidx;
        deq_mcast_o  <= (pick[gidx] == HEAD_MC);
        deq_handle_o <= (pick[gidx] == HEAD_MC) ? mc_head[gidx] : uc_head[gidx];
      end else begin
        deq_class_o  <= '0;
        deq_mcast_o  <= 1'b0;
        deq_handle_o <= '0;
      end
    end
  end

  // R6: output only follows a ready pulse
  p_deq_on_ready_r6: assert property (@(posedge clk) disable iff (rst)
    deq_valid_o |-> $past(deq_ready_i));
  // R5: no class above the served one held frames
  p_strict_prio_r5: assert property (@(posedge clk) disable iff (rst)
    deq_valid_o |-> ((($past(nonempty)) >> deq_class_o) >> 1) == '0);
  // R7/R8: congested class from a source without pause gets dropped
  p_class_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_i && !rsp_fc_en_i && occ[rsp_class_i] >= lim[rsp_class_i]) |=> drop_o);
  p_drop_has_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> $past(rsp_valid_i));
  // R9: pause only toward sources that accept it
  p_fc_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    fc_req_o |-> $past(rsp_fc_en_i));
  // R10: duplicate pulse only for accepted multicast
  p_dup_only_mc_r10: assert property (@(posedge clk) disable iff (rst)
    mc_dup_o |-> ($past(rsp_mcast_i) && !drop_o));
endmodule

// File: tb/test_txq_port_mgr.sv
`timescale 1ns/1ps
module test_txq_port_mgr;
  localparam int HW    = 6;
  localparam int NC    = 4;
  localparam int CLS_W = 2;
  localparam int CNT_W = HW + 2;
  localparam int NV    = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsp_valid_i = 1'b0, rsp_mcast_i = 1'b0, rsp_fc_en_i = 1'b0, deq_ready_i = 1'b0;
  logic [HW-1:0] rsp_handle_i = '0;
  logic [CLS_W-1:0] rsp_class_i = '0;
  logic [2:0] rsp_src_i = '0;
  logic [NC*CNT_W-1:0] class_limit_i = {NC{8'd3}};
  logic drop_o, fc_req_o, mc_dup_o, deq_valid_o, deq_mcast_o;
  logic [2:0] fc_port_o;
  logic [HW-1:0] mc_dup_handle_o, deq_handle_o;
  logic [CLS_W-1:0] deq_class_o;

  int nvec = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txq_port_mgr #(.HIGH_SPEED(1'b1)) i_txq_port_mgr (
    .clk, .rst, .rsp_valid_i, .rsp_handle_i, .rsp_mcast_i, .rsp_class_i,
    .rsp_src_i, .rsp_fc_en_i, .class_limit_i, .deq_ready_i,
    .drop_o, .fc_req_o, .fc_port_o, .mc_dup_o, .mc_dup_handle_o,
    .deq_valid_o, .deq_handle_o, .deq_class_o, .deq_mcast_o
  );

  // Vector: req[27:24] op[23] h[22:17] mc[16] cls[15:14] fc[13] src[12:10]
  //         exp_drop[9] exp_fc[8] exp_valid[7] exp_h[6:1] exp_mc[0]
  function automatic logic [27:0] E(int req, int h, int mc, int cls, int fc, int src,
                                    int ed, int ef);
    return {4'(req), 1'b0, 6'(h), 1'(mc), 2'(cls), 1'(fc), 3'(src), 1'(ed), 1'(ef), 8'b0};
  endfunction
  function automatic logic [27:0] D(int req, int v, int h, int cls, int mc);
    return {4'(req), 1'b1, 6'b0, 1'b0, 2'(cls), 1'b0, 3'b0, 2'b0, 1'(v), 6'(h), 1'(mc)};
  endfunction

  localparam logic [27:0] VECS [NV] = '{
    E(2, 5, 0, 0, 0, 0, 0, 0),   // R2 unicast c0
    E(10, 9, 1, 0, 0, 0, 0, 0),  // R10 multicast c0, dup pulse
    E(2, 7, 0, 0, 0, 0, 0, 0),   // R2
    E(5, 12, 0, 2, 0, 0, 0, 0),  // R5 class 2 entry
    D(5, 1, 12, 2, 0),           // R5 highest class first
    D(4, 1, 5, 0, 0),            // R4 older unicast head
    D(4, 1, 9, 0, 1),            // R4 then multicast
    D(2, 1, 7, 0, 0),            // R2
    D(6, 0, 0, 0, 0),            // R6 empty
    E(7, 20, 0, 1, 0, 0, 0, 0),  // R7
    E(10, 21, 1, 1, 0, 0, 0, 0), // R10
    E(7, 22, 0, 1, 0, 0, 0, 0),  // R7
    E(8, 23, 0, 1, 0, 0, 1, 0),  // R8 limit reached, no pause -> drop
    E(9, 24, 0, 1, 1, 5, 0, 1),  // R9 limit reached, pause port 5
    D(9, 1, 20, 1, 0),
    D(4, 1, 21, 1, 1),
    D(2, 1, 22, 1, 0),
    D(9, 1, 24, 1, 0),           // R9 paused frame was queued
    D(6, 0, 0, 0, 0),            // R6
    E(3, 30, 1, 3, 1, 2, 0, 0),  // R3
    E(3, 31, 1, 3, 1, 2, 0, 0),
    E(3, 32, 1, 3, 1, 2, 0, 0),
    E(9, 33, 1, 3, 1, 2, 0, 1),  // R9 queued with pause, FIFO now full
    E(3, 34, 1, 3, 1, 2, 1, 1),  // R3 full FIFO drops even with pause
    D(3, 1, 30, 3, 1),
    D(3, 1, 31, 3, 1),
    D(3, 1, 32, 3, 1),
    D(3, 1, 33, 3, 1),
    D(6, 0, 0, 0, 0)
  };

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a falling edge; checks at the next falling edge
  task automatic enq(input int req, input int h, input int mc, input int cls,
                     input int fc, input int src, input int ed, input int ef);
    logic [15:0] got, exp;
    logic dup;
    rsp_valid_i = 1'b1; rsp_handle_i = HW'(h); rsp_mcast_i = 1'(mc);
    rsp_class_i = CLS_W'(cls); rsp_fc_en_i = 1'(fc); rsp_src_i = 3'(src);
    @(negedge clk);
    rsp_valid_i = 1'b0;
    dup = (mc != 0) && (ed == 0);
    got = {3'b0, drop_o, fc_req_o, fc_port_o, mc_dup_o, mc_dup_handle_o, deq_valid_o};
    exp = {3'b0, 1'(ed), 1'(ef), (ef != 0) ? 3'(src) : 3'b0, dup,
           dup ? HW'(h) : HW'(0), 1'b0};
    chk(req, got, exp);
  endtask

  task automatic deq(input int req, input int v, input int h, input int cls, input int mc);
    logic [15:0] got, exp;
    deq_ready_i = 1'b1;
    @(negedge clk);
    deq_ready_i = 1'b0;
    got = {5'b0, deq_valid_o, deq_handle_o, deq_class_o, deq_mcast_o, drop_o};
    exp = {5'b0, 1'(v), (v != 0) ? HW'(h) : HW'(0), (v != 0) ? CLS_W'(cls) : CLS_W'(0),
           (v != 0) ? 1'(mc) : 1'b0, 1'b0};
    chk(req, got, exp);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs cleared under reset
    chk(11, {drop_o, fc_req_o, mc_dup_o, deq_valid_o, 12'b0}, 16'h0);
    rst = 1'b0;
    deq(11, 0, 0, 0, 0);  // R11 queues empty after reset
    // R1: four classes give a 2-bit class field
    chk(1, 16'($bits(deq_class_o)), 16'd2);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VECS[i];
      if (v[23]) deq(int'(v[27:24]), int'(v[7]), int'(v[6:1]), int'(v[15:14]), int'(v[0]));
      else enq(int'(v[27:24]), int'(v[22:17]), int'(v[16]), int'(v[15:14]),
               int'(v[13]), int'(v[12:10]), int'(v[9]), int'(v[8]));
    end

    // R7: port-wide reserve stops a class far below its own limit
    class_limit_i = {NC{8'd60}};
    for (int h = 0; h < 12; h++) enq(7, h, 0, 0, 0, 0, 0, 0);
    enq(7, 12, 0, 0, 0, 0, 1, 0);
    enq(9, 13, 0, 0, 1, 1, 0, 1);
    for (int h = 0; h < 12; h++) deq(2, 1, h, 0, 0);
    deq(9, 1, 13, 0, 0);
    deq(6, 0, 0, 0, 0);

    // R4: age order survives stamp wraparound
    for (int k = 0; k < 256; k++) begin
      enq(10, 1, 1, 2, 0, 0, 0, 0);
      enq(2, 2, 0, 2, 0, 0, 0, 0);
      deq(4, 1, 1, 2, 1);
      deq(4, 1, 2, 2, 0);
    end

    // R12: push and pop on a one-entry list in the same cycle
    enq(12, 40, 0, 0, 0, 0, 0, 0);
    rsp_valid_i = 1'b1; rsp_handle_i = HW'(41); rsp_mcast_i = 1'b0;
    rsp_class_i = '0; rsp_fc_en_i = 1'b0; deq_ready_i = 1'b1;
    @(negedge clk);
    rsp_valid_i = 1'b0; deq_ready_i = 1'b0;
    chk(12, {8'b0, deq_valid_o, drop_o, deq_handle_o}, {8'b0, 1'b1, 1'b0, 6'd40});
    deq(12, 1, 41, 0, 0);
    deq(12, 0, 0, 0, 0);

    // R11: reset mid-run discards queued frames
    enq(11, 50, 0, 1, 0, 0, 0, 0);
    enq(11, 51, 1, 3, 0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    deq(11, 0, 0, 0, 0);

    finish_run();
  end
endmodule